// File: doc/BRIEF.md
# Spread-Spectrum Triangle Dither Generator

This block produces a slowly varying digital offset that is subtracted from the frequency-control word of a programmable oscillator. The offset follows a triangle wave, so the oscillator sweeps its frequency down from the programmed value and back again. This spreads the energy of the output clock over a band that lies entirely below the nominal frequency. Everything runs on the master clock that the oscillator itself produces.

Two select inputs shape the sweep. A 2-bit rate select sets the triangle period to 8192, 4096 or 2048 master-clock cycles. A 3-bit depth select sets the peak offset as a coded percentage of the control word. A spread-enable input gates the whole function. The block drives two outputs: the offset, in control-word LSBs, and the control word minus that offset, clamped at zero.

Top module: `spread_dither`

## Requirements
- R1: While `rst_n` is low, both outputs are zero. On the first clock after release with spread disabled, `result_o` equals `ctrl_word_i` and `dither_off_o` is zero.
- R2: The rate code sets the triangle period in master-clock cycles: 2'b00 gives 8192, 2'b01 gives 4096 and 2'b10 gives 2048. The phase counts up from zero through the period. The offset is zero at phase zero.
- R3: The peak offset is (W>>s)+(W>>(s+2))+(W>>(s+4)), where W is the control word. The shift s depends on the depth code: 3'b000 gives s=8 (about 0.5 %), 3'b001 gives s=7 (1 %), 3'b010 gives s=6 (2 %), 3'b100 gives s=5 (4 %) and 3'b111 gives s=4 (8 %).
- R4: At phase p of a period P, the offset one cycle later is floor(peak*t/(P/2)). Here t is p while p < P/2, and P-p otherwise. This makes a triangle that peaks exactly at p = P/2.
- R5: While `spread_en_i` is low, the offset is zero from the next clock on. When spread is enabled again, the triangle restarts at phase zero.
- R6: The depth codes 3'b011, 3'b101 and 3'b110 and the rate code 2'b11 are reserved. With a reserved code the offset stays zero. The inputs are sampled again on every following cycle until a valid pair appears.
- R7: `result_o` equals `ctrl_word_i` minus the new offset, both taken at the same clock edge. If the offset is larger than the word, `result_o` is zero.
- R8: The rate, the depth and the control word used for the peak are captured only when a period starts. A change in the middle of a period takes effect at the next phase-zero point.
- R9: The offset never exceeds the captured peak, so `result_o` never exceeds the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spread_en_i | input | 1 | High enables the dither |
| rate_sel_i | input | 2 | Triangle period select |
| depth_sel_i | input | 3 | Peak depth select |
| ctrl_word_i | input | WORD_W | Programmed frequency-control word |
| dither_off_o | output | WORD_W | Offset to subtract, in control-word LSBs |
| result_o | output | WORD_W | Control word minus offset, clamped at zero |

## Verification
The assertions take the following for granted:
- The select inputs and the control word change only between clock edges.
- The peak is far smaller than half a period, so the offset at the last phase of a period rounds to zero.

The relation between the result and the word also assumes that the word is sampled at the same edge as the offset it is paired with. The stimulus changes inputs only on the falling clock edge and keeps the control word at or below 1023. It exercises mid-period changes of rate, depth and word, and it lowers the word below the running offset to reach the clamp.

// File: rtl/sd_pkg.sv
`timescale 1ns/1ps
// Package sd_pkg
// Shared types and decode helpers for the spread dither generator.
// Assumes depth codes are 3 bits wide; unlisted codes are reserved.
package sd_pkg;

    // Decoded depth: whether the code is usable and its base right shift
    typedef struct packed {
        logic       valid;
        logic [3:0] shift;
    } depth_sel_t;

    // Map a depth code to its base shift (larger shift = shallower dither)
    function automatic depth_sel_t decode_depth(input logic [2:0] code);
        depth_sel_t d;
        d.valid = 1'b1;
        case (code)
            3'b000:  d.shift = 4'd8;
            3'b001:  d.shift = 4'd7;
            3'b010:  d.shift = 4'd6;
            3'b100:  d.shift = 4'd5;
            3'b111:  d.shift = 4'd4;
            default: begin
                d.valid = 1'b0;
                d.shift = 4'd8;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sd_depth.sv
`timescale 1ns/1ps
// Module sd_depth
// Combinational peak-offset calculator. The peak is a sum of TERMS
// right-shifted copies of the control word, spaced STRIDE bits apart,
// starting from the base shift picked by the depth code.
// Assumes the base shift plus the widest term shift stays below 32.
module sd_depth
    import sd_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int TERMS  = 3,
    parameter int STRIDE = 2
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [2:0]        depth_i,
    output logic [WORD_W-1:0] peak_o,
    output logic              valid_o
);

    localparam int ACC_W = WORD_W + $clog2(TERMS + 1);

    depth_sel_t        sel;
    logic [WORD_W-1:0] term [TERMS];
    logic [ACC_W-1:0]  acc;

    // Decode the requested depth
    always_comb sel = decode_depth(depth_i);

    // One shifted copy of the word per term
    for (genvar g = 0; g < TERMS; g++) begin : g_term
        assign term[g] = word_i >> (32'(sel.shift) + STRIDE * g);
    end

    // Sum of the shifted copies
    always_comb begin
        acc = '0;
        for (int k = 0; k < TERMS; k++) begin
            acc = acc + ACC_W'(term[k]);
        end
    end

    assign peak_o  = WORD_W'(acc);
    assign valid_o = sel.valid;

endmodule

// File: rtl/sd_phase.sv
`timescale 1ns/1ps
// Module sd_phase
// Triangle phase counter and per-period configuration capture.
// At each period start (or while idle) it samples rate, depth validity
// and the peak, then counts phase 0 .. 2**logp - 1.
// Assumes rate codes at or above RATES are reserved.
module sd_phase #(
    parameter int WORD_W  = 10,
    parameter int LOG_MIN = 11,
    parameter int RATES   = 3,
    localparam int LOG_MAX = LOG_MIN + RATES - 1,
    localparam int PH_W    = LOG_MAX,
    localparam int LP_W    = $clog2(LOG_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [1:0]        rate_i,
    input  logic              depth_ok_i,
    input  logic [WORD_W-1:0] peak_i,
    output logic [PH_W-1:0]   ph_o,
    output logic [LP_W-1:0]   logp_o,
    output logic              act_o,
    output logic [WORD_W-1:0] peak_o
);

    logic [PH_W-1:0]   ph_q;
    logic [LP_W-1:0]   logp_q;
    logic              act_q;
    logic [WORD_W-1:0] peak_q;
    logic [PH_W-1:0]   last_ph;
    logic              rate_ok;
    logic              load;

    // Last phase of the captured period
    assign last_ph = {PH_W{1'b1}} >> (LP_W'(LOG_MAX) - logp_q);
    // Rate code lies in the supported set
    assign rate_ok = 32'(rate_i) < RATES;
    // Start a new period when idle or at the end of the current one
    assign load    = !act_q || (ph_q == last_ph);

    // Phase advance and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            logp_q <= LP_W'(LOG_MAX - 1);
            act_q  <= 1'b0;
            peak_q <= '0;
        end else if (!en_i) begin
            ph_q   <= '0;
            act_q  <= 1'b0;
        end else if (load) begin
            ph_q   <= '0;
            act_q  <= rate_ok && depth_ok_i;
            logp_q <= LP_W'(LOG_MAX - 32'(rate_i));
            peak_q <= peak_i;
        end else begin
            ph_q   <= ph_q + 1'b1;
        end
    end

    assign ph_o   = ph_q;
    assign logp_o = logp_q;
    assign act_o  = act_q;
    assign peak_o = peak_q;

endmodule

// File: rtl/sd_shape.sv
`timescale 1ns/1ps
// Module sd_shape
// Folds the phase into a triangle, scales it by the captured peak and
// registers both the offset and the clamped result word.
// Assumes logp_i >= 1 and peak_i < 2**WORD_W.
module sd_shape #(
    parameter int WORD_W = 10,
    parameter int PH_W   = 13,
    parameter int LP_W   = 4,
    localparam int P_W   = PH_W + 1,
    localparam int PR_W  = WORD_W + P_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              act_i,
    input  logic [PH_W-1:0]   ph_i,
    input  logic [LP_W-1:0]   logp_i,
    input  logic [WORD_W-1:0] peak_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] off_o,
    output logic [WORD_W-1:0] res_o
);

    logic [P_W-1:0]    period;
    logic [P_W-1:0]    half;
    logic [P_W-1:0]    ph_ext;
    logic [P_W-1:0]    tri_v;
    logic [PR_W-1:0]   prod;
    logic [WORD_W-1:0] off_nxt;
    logic [WORD_W-1:0] res_nxt;
    logic [WORD_W-1:0] off_q;
    logic [WORD_W-1:0] res_q;

    // Period length and half period
    assign period = P_W'(1) << logp_i;
    assign half   = period >> 1;
    assign ph_ext = {1'b0, ph_i};

    // Rising ramp in the first half, falling ramp in the second
    assign tri_v = (ph_ext < half) ? ph_ext : (period - ph_ext);

    // Scale the triangle so that its top equals the peak
    assign prod    = {{P_W{1'b0}}, peak_i} * {{WORD_W{1'b0}}, tri_v};
    assign off_nxt = (en_i && act_i) ? WORD_W'(prod >> (logp_i - LP_W'(1))) : '0;

    // Subtract with a floor at zero
    assign res_nxt = (word_i >= off_nxt) ? (word_i - off_nxt) : '0;

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            res_q <= '0;
        end else begin
            off_q <= off_nxt;
            res_q <= res_nxt;
        end
    end

    assign off_o = off_q;
    assign res_o = res_q;

endmodule

// File: rtl/spread_dither.sv
`timescale 1ns/1ps
// Module spread_dither (top)
// One-sided triangle dither for a frequency-control word. The output
// offset is subtracted from the word to sweep the oscillator downward.
// Assumes all inputs are synchronous to clk.
module spread_dither #(
    parameter int WORD_W  = 10,
    parameter int LOG_MIN = 11,
    parameter int RATES   = 3,
    parameter int TERMS   = 3,
    parameter int STRIDE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spread_en_i,
    input  logic [1:0]        rate_sel_i,
    input  logic [2:0]        depth_sel_i,
    input  logic [WORD_W-1:0] ctrl_word_i,
    output logic [WORD_W-1:0] dither_off_o,
    output logic [WORD_W-1:0] result_o
);

    localparam int LOG_MAX = LOG_MIN + RATES - 1;
    localparam int PH_W    = LOG_MAX;
    localparam int LP_W    = $clog2(LOG_MAX + 1);

    logic [WORD_W-1:0] peak_live;
    logic              depth_ok;
    logic [PH_W-1:0]   ph_w;
    logic [LP_W-1:0]   logp_w;
    logic              act_w;
    logic [WORD_W-1:0] peak_w;

    sd_depth #(
        .WORD_W (WORD_W),
        .TERMS  (TERMS),
        .STRIDE (STRIDE)
    ) u_depth (
        .word_i  (ctrl_word_i),
        .depth_i (depth_sel_i),
        .peak_o  (peak_live),
        .valid_o (depth_ok)
    );

    sd_phase #(
        .WORD_W  (WORD_W),
        .LOG_MIN (LOG_MIN),
        .RATES   (RATES)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (spread_en_i),
        .rate_i     (rate_sel_i),
        .depth_ok_i (depth_ok),
        .peak_i     (peak_live),
        .ph_o       (ph_w),
        .logp_o     (logp_w),
        .act_o      (act_w),
        .peak_o     (peak_w)
    );

    sd_shape #(
        .WORD_W (WORD_W),
        .PH_W   (PH_W),
        .LP_W   (LP_W)
    ) u_shape (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (spread_en_i),
        .act_i  (act_w),
        .ph_i   (ph_w),
        .logp_i (logp_w),
        .peak_i (peak_w),
        .word_i (ctrl_word_i),
        .off_o  (dither_off_o),
        .res_o  (result_o)
    );

endmodule

// File: rtl/sd_checker.sv
`timescale 1ns/1ps
// Module sd_checker
// Temporal properties of spread_dither, attached through bind.
// Assumes peak values stay below half the shortest period.
module sd_checker #(
    parameter int WORD_W = 10,
    parameter int PH_W   = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spread_en_i,
    input logic [WORD_W-1:0] ctrl_word_i,
    input logic [WORD_W-1:0] dither_off_o,
    input logic [WORD_W-1:0] result_o,
    input logic              act_w,
    input logic [PH_W-1:0]   ph_w,
    input logic [WORD_W-1:0] peak_w
);

    // Spread disabled forces a zero offset on the next cycle
    p_spread_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en_i |=> dither_off_o == '0);

    // Idle or reserved-code state gives zero offset
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !act_w |=> dither_off_o == '0);

    // Offset at phase zero is zero
    p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && spread_en_i && ph_w == '0) |=> dither_off_o == '0);

    // Offset bounded by the captured peak
    p_peak_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dither_off_o <= $past(peak_w));

    // Result never above the word it was formed from
    p_below_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_o <= $past(ctrl_word_i));

    // Result is word minus offset unless clamped at zero
    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o == '0) ||
        ((WORD_W+1)'(result_o) + (WORD_W+1)'(dither_off_o) == (WORD_W+1)'($past(ctrl_word_i))));

    // Captured peak holds inside a period
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && ph_w != '0) |-> $stable(peak_w));

endmodule

bind spread_dither sd_checker #(
    .WORD_W (WORD_W),
    .PH_W   (PH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spread_en_i  (spread_en_i),
    .ctrl_word_i  (ctrl_word_i),
    .dither_off_o (dither_off_o),
    .result_o     (result_o),
    .act_w        (act_w),
    .ph_w         (ph_w),
    .peak_w       (peak_w)
);

// File: tb/spread_dither_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for spread_dither: a reference process pushes the
// expected outputs every edge, a monitor pops and compares them.
module spread_dither_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] rate = 2'b01;
    logic [2:0] depth = 3'b000;
    logic [9:0] word = '0;
    logic [9:0] off;
    logic [9:0] res;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R1";
    bit done = 0;

    typedef struct packed { logic [9:0] off; logic [9:0] res; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    spread_dither dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en_i  (en),
        .rate_sel_i   (rate),
        .depth_sel_i  (depth),
        .ctrl_word_i  (word),
        .dither_off_o (off),
        .result_o     (res)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Peak from depth code per R3; valid flag clear for reserved codes
    function automatic int m_peak(input int w, input int code, output bit ok);
        int s;
        ok = 1;
        case (code)
            0: s = 8;
            1: s = 7;
            2: s = 6;
            4: s = 5;
            7: s = 4;
            default: begin s = 8; ok = 0; end
        endcase
        return (w >> s) + (w >> (s + 2)) + (w >> (s + 4));
    endfunction

    // Reference model, per R2/R4/R5/R6/R7/R8
    int m_ph = 0, m_lp = 12, m_peak_q = 0;
    bit m_act = 0;
    always @(posedge clk) begin
        exp_t e;
        int p, t, o, pk;
        bit dok;
        if (!rst_n) begin
            m_ph = 0; m_act = 0; m_lp = 12; m_peak_q = 0;
            e.off = 0; e.res = 0;
        end else begin
            p = 1 << m_lp;
            t = (m_ph < p / 2) ? m_ph : p - m_ph;
            o = (en && m_act) ? (m_peak_q * t) >> (m_lp - 1) : 0;
            e.off = 10'(o);
            e.res = (int'(word) >= o) ? 10'(int'(word) - o) : 10'd0;
            if (!en) begin
                m_ph = 0; m_act = 0;
            end else if (!m_act || m_ph == p - 1) begin
                pk = m_peak(int'(word), int'(depth), dok);
                m_act = dok && (rate != 2'b11);
                m_lp = 13 - int'(rate);
                m_peak_q = pk;
                m_ph = 0;
            end else begin
                m_ph = m_ph + 1;
            end
        end
        exp_q.push_back(e);
    end

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            check(off == e.off, cur_tag, int'(off), int'(e.off));
            check(res == e.res, "R7", int'(res), int'(e.res));
        end
    end

    task automatic run_measure(input int n, output int mx, output int idx);
        mx = -1; idx = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (int'(off) > mx) begin mx = int'(off); idx = i; end
        end
    endtask

    task automatic pause_spread();
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        check(off == 0, "R5", int'(off), 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        report();
    end

    initial begin
        int mx, idx;
        // R1 reset state
        word = 10'd600;
        repeat (4) @(negedge clk);
        check(off == 0, "R1", int'(off), 0);
        check(res == 0, "R1", int'(res), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res == 10'd600, "R1", int'(res), 600);
        check(off == 0, "R1", int'(off), 0);

        // R2/R3/R4: 2048 period, 8 %, word 1000 -> peak 80 at negedge 1026
        cur_tag = "R4";
        @(negedge clk); rate = 2'b10; depth = 3'b111; word = 10'd1000; en = 1'b1;
        run_measure(2048, mx, idx);
        check(mx == 80, "R3", mx, 80);
        check(idx == 1026, "R2", idx, 1026);
        run_measure(2048, mx, idx);
        pause_spread();

        // R2: 8192 period
        @(negedge clk); rate = 2'b00; en = 1'b1;
        run_measure(8192, mx, idx);
        check(idx == 4098, "R2", idx, 4098);
        check(mx == 80, "R3", mx, 80);
        pause_spread();

        // R3: remaining depths at 4096 period
        for (int d = 0; d < 4; d++) begin
            int code, expk;
            code = (d == 3) ? 4 : d;
            expk = (d == 0) ? 3 : (d == 1) ? 8 : (d == 2) ? 18 : 39;
            @(negedge clk); rate = 2'b01; depth = 3'(code); en = 1'b1;
            run_measure(4096, mx, idx);
            check(mx == expk, "R3", mx, expk);
            check(idx == 2050, "R2", idx, 2050);
            pause_spread();
        end

        // R6: reserved codes
        cur_tag = "R6";
        for (int d = 0; d < 4; d++) begin
            @(negedge clk);
            rate = (d == 3) ? 2'b11 : 2'b01;
            depth = (d == 0) ? 3'b011 : (d == 1) ? 3'b101 : (d == 2) ? 3'b110 : 3'b111;
            en = 1'b1;
            run_measure(300, mx, idx);
            check(mx == 0, "R6", mx, 0);
            pause_spread();
        end

        // R5: disable mid-period, phase restarts
        cur_tag = "R5";
        @(negedge clk); rate = 2'b10; depth = 3'b111; en = 1'b1;
        repeat (600) @(negedge clk);
        check(off != 0, "R5", int'(off), 1);
        pause_spread();
        @(negedge clk); en = 1'b1;
        run_measure(2048, mx, idx);
        check(idx == 1026, "R5", idx, 1026);
        pause_spread();

        // R8: mid-period change waits for the period end
        cur_tag = "R8";
        @(negedge clk); rate = 2'b10; depth = 3'b111; word = 10'd1000; en = 1'b1;
        repeat (300) @(negedge clk);
        rate = 2'b00; depth = 3'b000; word = 10'd500;
        run_measure(1748, mx, idx);
        check(mx == 80, "R8", mx, 80);
        check(idx == 726, "R8", idx, 726);
        run_measure(8192, mx, idx);
        check(mx == 1, "R8", mx, 1);
        pause_spread();

        // R7: word dropped below running offset -> clamp
        cur_tag = "R9";
        @(negedge clk); rate = 2'b10; depth = 3'b111; word = 10'd1023; en = 1'b1;
        repeat (1000) @(negedge clk);
        word = 10'd5;
        @(negedge clk);
        check(res == 0, "R7", int'(res), 0);
        check(off > 5, "R7", int'(off), 6);
        repeat (200) @(negedge clk);
        pause_spread();

        repeat (4) @(negedge clk);
        done = 1;
        report();
    end

endmodule